// File: doc/BRIEF.md
# Auto-Incrementing Byte ROM Port

This block puts a byte-wide ROM behind a single memory-mapped port on a 16-bit processor bus. The ROM is never addressed directly by the bus. The port keeps its own 16-bit internal address counter instead. Software loads that counter with two byte writes to an address register. It then streams bytes out of a data register. Every data access hands back the byte that was fetched ahead of time. The counter then steps forward and the next byte is fetched into the buffer.

The port decodes only a 1 KB window of the bus, so its two registers repeat throughout that window. Address bit 1 picks the register. Only the even (upper) byte lane of the bus carries data to and from the port. Every accepted access holds the processor's READY line low for a fixed stall. That stall leaves time for the internal fetch to finish.

Top module: `rom_port`

## Requirements
- R1: Only bus addresses whose bits 15..10 equal bits 15..10 of `BASE_ADDR` (default 0x9800) reach the port. A strobe outside that window leaves `bus_ready` high and changes no port state.
- R2: Inside the window, address bit 1 set selects the address register and bit 1 clear selects the data register. Bits 9..2 and bit 0 have no effect, so every alias behaves the same.
- R3: A data read returns the buffered byte for the current internal address A on `bus_rdata[15:8]`, with `bus_rdata[7:0]` zero, and then sets A to A+1 and refetches. The ROM byte at A is ((I*37+11) mod 256) XOR ((I>>5) mod 256), where I = A mod 1024.
- R4: A write to the address register uses only `bus_wdata[15:8]`. With the byte toggle clear, it loads A[15:8] and sets the toggle. With the toggle set, it loads A[7:0], clears the toggle and fetches the byte at the new A.
- R5: A write to the data register stores nothing in the ROM. It sets A to A+1, clears the toggle and fetches the byte at the new A.
- R6: `bus_ready` is high after reset. An accepted strobe drives it low from the following cycle for exactly 26 cycles (WAIT_CYC+HOLD_CYC), which gives a 28-cycle access counting the strobe cycle and the release cycle. Strobes that arrive while it is low are ignored.
- R7: Every data access, read or write, clears the address byte toggle. The next address write therefore loads the high byte.
- R8: A read of the address register returns A[15:8] while the toggle is clear and A[7:0] while it is set, and then inverts the toggle. It leaves A unchanged.
- R9: A write never changes `bus_rdata`. A read of the address register never loads A.
- R10: A steps from 0xFFFF to 0x0000.
- R11: Reset sets A to 0 and clears the toggle, and leaves the buffered byte undefined. After one dummy data read, the next data read returns the byte at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Processor byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data; only the upper byte is used |
| bus_rdata | output | 16 | Read data; byte on the upper lane, lower lane zero |
| bus_ready | output | 1 | Low while the port stalls the processor |

## Verification
The bench goes after the state coupling between the two registers. It leaves a high byte pending and then does a data access. A design that failed to clear the toggle would swap the halves of the next address it loads. It sends a stray write during the stall, which a port that accepted it would take as an address byte. It also checks the wrap at 0xFFFF, where a counter that did not wrap would stop or run past the top of the address space. It checks that a data write only advances the counter, and that the ROM stays unchanged after it. It checks aliased and odd addresses and a strobe outside the window, which a wrong decoder would answer or stall on. A cycle-level model checks the 26-cycle READY low time on every access, so a stall that is one cycle short or one cycle long shows up.

// File: rtl/rom_port_pkg.sv
package rom_port_pkg;

  // decoded bus operation for one cycle
  typedef struct packed {
    logic valid;    // strobe inside the window
    logic is_rd;    // read (otherwise write)
    logic is_addr;  // address register (otherwise data register)
  } port_op_t;

  // contents of the lookup ROM, computed rather than listed
  function automatic logic [7:0] rom_byte_f(input int unsigned idx);
    logic [7:0] mix;
    logic [7:0] hi;
    mix = 8'(idx * 37 + 11);
    hi  = 8'(idx >> 5);
    return mix ^ hi;
  endfunction

endpackage

// File: rtl/rp_decode.sv
module rp_decode
  import rom_port_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h9800,
  parameter int          WIN_BITS  = 10
) (
  input  logic [15:0] addr,
  input  logic        rd,
  input  logic        wr,
  output port_op_t    op
);
  localparam int TAG_W = 16 - WIN_BITS;
  localparam logic [TAG_W-1:0] TAG = BASE_ADDR[15:WIN_BITS];

  logic in_win;
  logic unused_dec;

  assign in_win     = (addr[15:WIN_BITS] == TAG);
  assign op.valid   = in_win & (rd | wr);
  assign op.is_rd   = rd;
  assign op.is_addr = addr[1];
  assign unused_dec = ^{addr[WIN_BITS-1:2], addr[0]};
endmodule

// File: rtl/rp_timer.sv
module rp_timer #(
  parameter int LOW_CYC = 26
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic go,
  output logic ready
);
  localparam int CW = $clog2(LOW_CYC + 1);

  logic          ready_q;
  logic [CW-1:0] cnt_q;

  assign go    = req & ready_q;
  assign ready = ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      cnt_q   <= '0;
    end else if (go) begin
      ready_q <= 1'b0;
      cnt_q   <= CW'(LOW_CYC - 1);
    end else if (!ready_q) begin
      if (cnt_q == '0) ready_q <= 1'b1;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rp_rom.sv
module rp_rom
  import rom_port_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = rom_byte_f(i);
  end

  always_ff @(posedge clk) rdata <= mem[raddr];
endmodule

// File: rtl/rp_prefetch.sv
module rp_prefetch (
  input  logic       clk,
  input  logic       rst,
  input  logic       fetch,   // address changed at this edge
  input  logic [7:0] rom_q,
  output logic [7:0] pf_byte
);
  // stage 1: ROM samples the new address; stage 2: capture its output
  logic req_d1, req_d2;
  logic [7:0] pf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d1 <= 1'b0;
      req_d2 <= 1'b0;
    end else begin
      req_d1 <= fetch;
      req_d2 <= req_d1;
    end
  end

  // buffer is deliberately left without reset
  always_ff @(posedge clk) begin
    if (req_d2) pf_q <= rom_q;
  end

  assign pf_byte = pf_q;
endmodule

// File: rtl/rp_addr_ctl.sv
module rp_addr_ctl
  import rom_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  port_op_t    op,
  input  logic [7:0]  wbyte,
  input  logic [7:0]  pf_byte,
  output logic [15:0] addr_q,
  output logic        tog_q,
  output logic [15:0] rdata_q,
  output logic        fetch
);
  logic data_acc, addr_wr, addr_rd, data_rd;

  assign data_acc = go & ~op.is_addr;
  assign data_rd  = data_acc & op.is_rd;
  assign addr_wr  = go & op.is_addr & ~op.is_rd;
  assign addr_rd  = go & op.is_addr & op.is_rd;
  assign fetch    = data_acc | (addr_wr & tog_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      tog_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (data_acc) begin
        addr_q <= addr_q + 16'd1;
        tog_q  <= 1'b0;
      end else if (addr_wr) begin
        if (tog_q) addr_q[7:0]  <= wbyte;
        else       addr_q[15:8] <= wbyte;
        tog_q <= ~tog_q;
      end else if (addr_rd) begin
        tog_q <= ~tog_q;
      end

      if (data_rd)      rdata_q <= {pf_byte, 8'h00};
      else if (addr_rd) rdata_q <= {(tog_q ? addr_q[7:0] : addr_q[15:8]), 8'h00};
    end
  end
endmodule

// File: rtl/rom_port.sv
module rom_port
  import rom_port_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h9800,
  parameter int          WIN_BITS  = 10,
  parameter int          MEM_CYC   = 2,
  parameter int          WAIT_CYC  = 4,
  parameter int          HOLD_CYC  = 22,
  parameter int          ROM_AW    = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_ready
);
  localparam int TOTAL_CYC = MEM_CYC + WAIT_CYC + HOLD_CYC;
  localparam int LOW_CYC   = TOTAL_CYC - 2;  // strobe and release cycles excluded

  port_op_t          op;
  logic              go;
  logic              fetch;
  logic [15:0]       addr_q;
  logic              tog_q;
  logic [7:0]        rom_q;
  logic [7:0]        pf_byte;
  logic              unused_lane;

  assign unused_lane = ^bus_wdata[7:0];

  rp_decode #(.BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .op(op)
  );

  rp_timer #(.LOW_CYC(LOW_CYC)) u_tmr (
    .clk(clk), .rst(rst), .req(op.valid), .go(go), .ready(bus_ready)
  );

  rp_addr_ctl u_ctl (
    .clk(clk), .rst(rst), .go(go), .op(op), .wbyte(bus_wdata[15:8]),
    .pf_byte(pf_byte), .addr_q(addr_q), .tog_q(tog_q),
    .rdata_q(bus_rdata), .fetch(fetch)
  );

  rp_rom #(.AW(ROM_AW)) u_rom (
    .clk(clk), .raddr(addr_q[ROM_AW-1:0]), .rdata(rom_q)
  );

  rp_prefetch u_pf (
    .clk(clk), .rst(rst), .fetch(fetch), .rom_q(rom_q), .pf_byte(pf_byte)
  );
endmodule

// File: rtl/rom_port_chk.sv
module rom_port_chk #(
  parameter int MEM_CYC  = 2,
  parameter int WAIT_CYC = 4,
  parameter int HOLD_CYC = 22
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_ready,
  input logic [15:0] bus_rdata,
  input logic        go,
  input logic        op_valid,
  input logic        op_rd,
  input logic        op_addr,
  input logic [15:0] addr_q,
  input logic        tog_q
);
  localparam int LOW_CYC = MEM_CYC + WAIT_CYC + HOLD_CYC - 2;
  localparam int LW = $clog2(LOW_CYC + 2);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)            low_cnt <= '0;
    else if (!bus_ready) low_cnt <= low_cnt + 1'b1;
    else                low_cnt <= '0;
  end

  // R6
  ready_short_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |-> (low_cnt < LW'(LOW_CYC)));
  // R6
  ready_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ready) |-> (low_cnt == LW'(LOW_CYC)));
  // R6
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && !go) |=> bus_ready);
  // R1
  outside_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && !op_valid) |=> bus_ready);
  // R3
  lanes_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[7:0] == 8'h00);
  // R9
  wr_keeps_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    (go && !op_rd) |=> $stable(bus_rdata));
  // R3
  incr_chk: assert property (@(posedge clk) disable iff (rst)
    (go && !op_addr) |=> (addr_q == $past(addr_q) + 16'd1));
  // R7
  tog_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (go && !op_addr) |=> !tog_q);
  // R8
  addr_rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (go && op_addr && op_rd) |=> $stable(addr_q));
endmodule

bind rom_port rom_port_chk #(.MEM_CYC(MEM_CYC), .WAIT_CYC(WAIT_CYC), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst(rst), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
  .go(go), .op_valid(op.valid), .op_rd(op.is_rd), .op_addr(op.is_addr),
  .addr_q(addr_q), .tog_q(tog_q)
);

// File: tb/sim_rom_port.sv
module sim_rom_port;
  localparam int CLK_PERIOD = 10;
  localparam int LOW_CYCLES = 26;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ready;

  int n_chk = 0;
  int n_fail = 0;
  bit model_on = 1'b0;

  rom_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_byte(input logic [15:0] a);
    int unsigned i;
    i = a % 1024;
    return 8'((i * 37 + 11) % 256) ^ 8'((i >> 5) % 256);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_low = 0;
  logic [15:0] m_addr = '0;
  bit          m_tog = 0;
  logic [15:0] m_rdata = '0;
  bit          m_rd_known = 1;
  bit          m_pf_known = 0;

  always @(posedge clk) begin
    bit inwin;
    inwin = (bus_addr[15:10] == 6'b100110);
    if (rst) begin
      m_low = 0; m_addr = '0; m_tog = 0; m_rdata = '0;
      m_rd_known = 1; m_pf_known = 0;
    end else if (m_low == 0 && inwin && (bus_rd || bus_wr)) begin
      m_low = LOW_CYCLES;
      if (!bus_addr[1]) begin
        if (bus_rd) begin
          m_rdata = {exp_byte(m_addr), 8'h00};
          m_rd_known = m_pf_known;
        end
        m_addr = m_addr + 16'd1;
        m_tog = 0;
        m_pf_known = 1;
      end else if (bus_rd) begin
        m_rdata = {(m_tog ? m_addr[7:0] : m_addr[15:8]), 8'h00};
        m_rd_known = 1;
        m_tog = !m_tog;
      end else begin
        if (m_tog) begin m_addr[7:0] = bus_wdata[15:8]; m_pf_known = 1; end
        else       m_addr[15:8] = bus_wdata[15:8];
        m_tog = !m_tog;
      end
    end else if (m_low > 0) begin
      m_low--;
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk(bus_ready === (m_low == 0), "R6 ready per cycle", {15'd0, bus_ready}, {15'd0, m_low == 0});
      if (m_rd_known)
        chk(bus_rdata === m_rdata, "R3 rdata per cycle", bus_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic acc(input bit rd, input logic [15:0] a, input logic [15:0] wd,
                     output logic [15:0] rv, output int lowc);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = !rd; bus_wdata = wd;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    lowc = 0;
    while (!bus_ready && lowc < 1000) begin
      lowc++;
      @(negedge clk);
    end
    rv = bus_rdata;
  endtask

  task automatic load_addr(input logic [15:0] a);
    logic [15:0] rv; int lc;
    acc(0, 16'h9802, {a[15:8], 8'hA5}, rv, lc);
    acc(0, 16'h9802, {a[7:0], 8'h5A}, rv, lc);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] rv, rv2;
    int lc;
    repeat (3) @(negedge clk);
    rst = 0;
    model_on = 1;
    @(negedge clk);
    chk(bus_ready === 1'b1, "R6 reset ready", {15'd0, bus_ready}, 16'd1);
    chk(bus_rdata === 16'h0000, "R11 reset rdata", bus_rdata, 16'h0000);

    // R11: dummy read, then byte at address 1
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(lc == LOW_CYCLES, "R6 low length read", 16'(lc), 16'(LOW_CYCLES));
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'd1), 8'h00}, "R11 read after dummy", rv, {exp_byte(16'd1), 8'h00});
    // R8: address readback, high then low
    acc(1, 16'h9802, 16'h0, rv, lc);
    chk(rv === 16'h0000, "R8 addr high", rv, 16'h0000);
    acc(1, 16'h9802, 16'h0, rv, lc);
    chk(rv === 16'h0200, "R8 addr low", rv, 16'h0200);

    // R4: two address writes, low lane junk
    acc(0, 16'h9802, 16'h12AB, rv, lc);
    chk(lc == LOW_CYCLES, "R6 low length write", 16'(lc), 16'(LOW_CYCLES));
    acc(0, 16'h9802, 16'h34CD, rv, lc);
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'h1234), 8'h00}, "R4 loaded address", rv, {exp_byte(16'h1234), 8'h00});
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'h1235), 8'h00}, "R3 increment", rv, {exp_byte(16'h1235), 8'h00});

    // R2: aliases inside the window
    acc(0, 16'h9BFE, 16'h01FF, rv, lc);
    acc(0, 16'h9A06, 16'h1000, rv, lc);
    acc(1, 16'h9BFC, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'h0110), 8'h00}, "R2 alias read", rv, {exp_byte(16'h0110), 8'h00});
    acc(1, 16'h9801, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'h0111), 8'h00}, "R2 odd address", rv, {exp_byte(16'h0111), 8'h00});

    // R5 and R9: data write advances only, leaves rdata
    acc(0, 16'h9800, 16'hFFFF, rv2, lc);
    chk(rv2 === rv, "R9 write keeps rdata", rv2, rv);
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'h0113), 8'h00}, "R5 write advanced", rv, {exp_byte(16'h0113), 8'h00});
    load_addr(16'h0112);
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'h0112), 8'h00}, "R5 rom unchanged", rv, {exp_byte(16'h0112), 8'h00});

    // R7: pending high byte dropped by a data access
    acc(0, 16'h9802, 16'h5500, rv, lc);
    acc(1, 16'h9800, 16'h0, rv, lc);
    acc(0, 16'h9802, 16'h0200, rv, lc);
    acc(0, 16'h9802, 16'h2000, rv, lc);
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'h0220), 8'h00}, "R7 toggle cleared", rv, {exp_byte(16'h0220), 8'h00});

    // R8 and R9: address reads do not load or move A
    acc(1, 16'h9802, 16'h0, rv, lc);
    chk(rv === 16'h0200, "R8 addr high again", rv, 16'h0200);
    acc(1, 16'h9802, 16'h0, rv, lc);
    chk(rv === 16'h2100, "R8 addr low again", rv, 16'h2100);
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'h0221), 8'h00}, "R9 addr read no load", rv, {exp_byte(16'h0221), 8'h00});

    // R1: strobes outside the window
    acc(1, 16'h9400, 16'h0, rv, lc);
    chk(lc == 0, "R1 no stall outside", 16'(lc), 16'd0);
    acc(0, 16'hA002, 16'h7700, rv, lc);
    chk(lc == 0, "R1 no stall outside wr", 16'(lc), 16'd0);
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'h0222), 8'h00}, "R1 state untouched", rv, {exp_byte(16'h0222), 8'h00});

    // R6: strobe during the stall is ignored
    load_addr(16'h0300);
    @(negedge clk);
    bus_addr = 16'h9800; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    repeat (4) @(negedge clk);
    bus_addr = 16'h9802; bus_wr = 1; bus_wdata = 16'h7700;
    @(negedge clk);
    bus_wr = 0;
    while (!bus_ready) @(negedge clk);
    chk(bus_rdata === {exp_byte(16'h0300), 8'h00}, "R6 stall read", bus_rdata, {exp_byte(16'h0300), 8'h00});
    acc(0, 16'h9802, 16'h0400, rv, lc);
    acc(0, 16'h9802, 16'h0000, rv, lc);
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'h0400), 8'h00}, "R6 stray strobe ignored", rv, {exp_byte(16'h0400), 8'h00});

    // R10: wrap at the top
    load_addr(16'hFFFF);
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'hFFFF), 8'h00}, "R10 top byte", rv, {exp_byte(16'hFFFF), 8'h00});
    acc(1, 16'h9800, 16'h0, rv, lc);
    chk(rv === {exp_byte(16'h0000), 8'h00}, "R10 wrapped byte", rv, {exp_byte(16'h0000), 8'h00});
    acc(1, 16'h9802, 16'h0, rv, lc);
    chk(rv === 16'h0000, "R10 wrapped addr high", rv, 16'h0000);
    acc(1, 16'h9802, 16'h0, rv, lc);
    chk(rv === 16'h0100, "R10 wrapped addr low", rv, 16'h0100);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule